// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a small set of interrupt sources and presents one active-low interrupt request to a processor. Each source has an enable bit, a 3-bit priority, a choice of edge or level sensing, and a programmed handler vector. The processor reads a vector register to learn which handler to run. A hardware stack of priority levels lets a higher-priority source interrupt a handler that is already running. An end-of-interrupt write returns the controller to the level it had before that handler started.

Some side effects must not happen when a debugger reads the vector register. For this case the block has a protect mode. In protect mode, reading the vector register only finds the winning source, returns its vector and memorizes it. The push onto the stack and the acknowledge of the source wait for a later write to the same register. A debugger can therefore read that register as often as it likes without disturbing the controller. When no enabled source is pending, a read returns a programmable spurious vector and changes nothing else.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_n is 1, protect mode is off (word 19 bit 0 reads 0), the status register (word 20) reads 0 and the current level is idle, which is below priority 0.
- R2: irq_n is 0 exactly when at least one enabled, pending source has a priority strictly greater than the current level. A disabled source never drives irq_n low.
- R3: A read of the vector register (word 16) returns the vector (word 8+i) of the pending enabled source with the highest priority. When several sources share that priority, the lowest source number wins. Only sources above the current level count.
- R4: In normal mode, a vector read that finds an active source does the following: it pushes the current level, makes that source's priority the current level, acknowledges the source, and loads the source number into the status register.
- R5: A vector read with no active source returns the spurious register (word 17). It leaves the stack, the current level and the status register unchanged.
- R6: A write to the end-of-interrupt register (word 18) pops the stack and restores the previous level. On an empty stack the write is ignored.
- R7: Writing 1 to bit 0 of word 19 turns protect mode on, and writing 0 turns it off. In protect mode, repeated vector reads return the same vector and leave the status, level and pending state unchanged. A later write to word 16, with any data, then pushes, acknowledges and updates the status using the memorized source.
- R8: In normal mode, a write to the vector register has no effect.
- R9: Source configuration is at word i, with bits [2:0] for the priority, bit 3 set for edge sensing and bit 4 for enable. An edge source latches pending on a rising input, and the acknowledge clears it. A level source follows its input, and the acknowledge does not clear it.
- R10: Nesting works: while one handler is stacked, a source of higher priority asserts irq_n again and can be taken. The stack holds 8 levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Interrupt source inputs, synchronous to clk |
| irq_n | output | 1 | Active-low interrupt request to the processor |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as bus_rd |

## Verification
The assertions assume that a cycle carries at most one bus operation, so a read and a write never coincide. They also assume that the source inputs are already synchronous to clk. The stack has no overflow check beyond an assertion. That assertion depends on each push strictly raising the level, which keeps the depth within the eight priority values. The bench tasks issue one strobe at a time, each for exactly one cycle. They change the source inputs only at falling edges and nest handlers only by rising priority.

// File: rtl/vic_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes a 5-bit word address space and at most 8 sources.
package vic_pkg;
    localparam int PRIO_W = 3;
    localparam int LVL_W  = PRIO_W + 1;   // level 0 = idle, p+1 = priority p

    localparam logic [4:0] ADR_CFG_BASE = 5'd0;
    localparam logic [4:0] ADR_VEC_BASE = 5'd8;
    localparam logic [4:0] ADR_VECRD    = 5'd16;
    localparam logic [4:0] ADR_SPUR     = 5'd17;
    localparam logic [4:0] ADR_EOI      = 5'd18;
    localparam logic [4:0] ADR_DBG      = 5'd19;
    localparam logic [4:0] ADR_STATUS   = 5'd20;

    typedef struct packed {
        logic              en;
        logic              edge_m;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/vic_src_pending.sv
// One source's pending state. An edge source latches on a rising input
// and is cleared by ack. A level source follows the registered input.
// Assumes src_in is already synchronous to clk.
module vic_src_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    input  logic edge_mode,
    input  logic ack,
    output logic pend
);
    logic src_q;
    logic edge_flag;
    logic rise;

    assign rise = src_in && !src_q;

    // Register the input and keep the latched edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= 1'b0;
            edge_flag <= 1'b0;
        end else begin
            src_q <= src_in;
            if (!edge_mode)
                edge_flag <= 1'b0;
            else if (rise)
                edge_flag <= 1'b1;
            else if (ack)
                edge_flag <= 1'b0;
        end
    end

    // Choose between the latched edge and the live level.
    assign pend = edge_mode ? edge_flag : src_q;

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && ack && !rise |=> !edge_flag); // R9
endmodule

// File: rtl/vic_arbiter.sv
// Picks the requesting source with the highest priority. Ties go to the
// lowest index. Purely combinational.
module vic_arbiter #(
    parameter int N_SRC = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]                     req,
    input  logic [N_SRC-1:0][vic_pkg::PRIO_W-1:0] prio,
    output logic                                 found,
    output logic [SRC_W-1:0]                     idx,
    output logic [vic_pkg::PRIO_W-1:0]           best_prio
);
    // Scan upward and replace only on a strictly higher priority.
    always_comb begin
        found     = 1'b0;
        idx       = '0;
        best_prio = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (!found || prio[i] > best_prio)) begin
                found     = 1'b1;
                idx       = SRC_W'(i);
                best_prio = prio[i];
            end
        end
    end

    // The chosen index must point at a real request.
    always_comb begin
        if (found) begin
            AST_WINNER_REQUESTED: assert (req[idx]); // R3
        end
    end
endmodule

// File: rtl/vic_prio_stack.sv
// Stack of saved priority levels. A push saves the current level and
// installs a new one. A pop restores the saved level and is ignored when
// the stack is empty. Assumes push and pop never coincide.
module vic_prio_stack #(
    parameter int DEPTH = 8,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [vic_pkg::LVL_W-1:0] push_lvl,
    input  logic                      pop,
    output logic [vic_pkg::LVL_W-1:0] cur_lvl
);
    logic [vic_pkg::LVL_W-1:0] stk [DEPTH];
    logic [SP_W-1:0]           sp;
    logic [SP_W-1:0]           sp_m1;

    assign sp_m1 = sp - SP_W'(1);

    // Save or restore levels and move the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp      <= '0;
            cur_lvl <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push) begin
            stk[sp[IDX_W-1:0]] <= cur_lvl;
            cur_lvl            <= push_lvl;
            sp                 <= sp + SP_W'(1);
        end else if (pop && sp != '0) begin
            cur_lvl <= stk[sp_m1[IDX_W-1:0]];
            sp      <= sp_m1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> sp < SP_W'(DEPTH)); // R10
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && sp == '0 |=> sp == '0 && $stable(cur_lvl)); // R6
    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_lvl > cur_lvl |=> cur_lvl > $past(cur_lvl)); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored priority interrupt controller top. It holds the per-source
// configuration, the vectors, the spurious vector, the protect-mode bit
// and the status register, and decodes the register bus. Assumes at most
// one bus strobe per cycle and N_SRC <= 8.
module irq_vector_ctrl #(
    parameter int N_SRC       = 4,
    parameter int DATA_W      = 32,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    output logic              irq_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import vic_pkg::*;

    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    src_cfg_t               cfg_q [N_SRC];
    logic [DATA_W-1:0]      vec_q [N_SRC];
    logic [DATA_W-1:0]      spur_q;
    logic                   protect_q;
    logic [SRC_W-1:0]       status_q;
    logic                   mem_valid_q;
    logic [SRC_W-1:0]       mem_src_q;
    logic [PRIO_W-1:0]      mem_prio_q;

    logic [N_SRC-1:0]              pend, req, ack;
    logic [N_SRC-1:0][PRIO_W-1:0]  prio_vec;
    logic                          best_found;
    logic [SRC_W-1:0]              best_idx;
    logic [PRIO_W-1:0]             best_prio;
    logic [LVL_W-1:0]              cur_lvl, push_lvl;
    logic                          active, rd_vec, wr_vec, wr_eoi;
    logic                          normal_take, protect_take, push;
    logic [SRC_W-1:0]              ack_src;
    logic [2:0]                    word_idx;

    // Per-source pending logic and request qualification.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        vic_src_pending u_pend (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_in    (src_in[g]),
            .edge_mode (cfg_q[g].edge_m),
            .ack       (ack[g]),
            .pend      (pend[g])
        );
        assign req[g]      = pend[g] && cfg_q[g].en;
        assign prio_vec[g] = cfg_q[g].prio;
        assign ack[g]      = push && ack_src == SRC_W'(g);
    end

    vic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .req       (req),
        .prio      (prio_vec),
        .found     (best_found),
        .idx       (best_idx),
        .best_prio (best_prio)
    );

    vic_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_lvl (push_lvl),
        .pop      (wr_eoi),
        .cur_lvl  (cur_lvl)
    );

    // Work out the active interrupt and the side effects of a bus access.
    always_comb begin
        active       = best_found && ({1'b0, best_prio} + LVL_W'(1) > cur_lvl);
        rd_vec       = bus_rd && bus_addr == ADR_VECRD;
        wr_vec       = bus_wr && bus_addr == ADR_VECRD;
        wr_eoi       = bus_wr && bus_addr == ADR_EOI;
        normal_take  = rd_vec && !protect_q && active;
        protect_take = wr_vec && protect_q && mem_valid_q;
        push         = normal_take || protect_take;
        ack_src      = normal_take ? best_idx : mem_src_q;
        push_lvl     = normal_take ? {1'b0, best_prio} + LVL_W'(1)
                                   : {1'b0, mem_prio_q} + LVL_W'(1);
    end

    assign irq_n    = !active;
    assign word_idx = bus_addr[2:0];

    // Configuration, protect bit, memorized interrupt and status updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) begin
                cfg_q[i] <= '0;
                vec_q[i] <= '0;
            end
            spur_q      <= '0;
            protect_q   <= 1'b0;
            status_q    <= '0;
            mem_valid_q <= 1'b0;
            mem_src_q   <= '0;
            mem_prio_q  <= '0;
        end else begin
            if (bus_wr) begin
                for (int i = 0; i < N_SRC; i++) begin
                    if (bus_addr == ADR_CFG_BASE + 5'(i))
                        cfg_q[i] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
                    if (bus_addr == ADR_VEC_BASE + 5'(i))
                        vec_q[i] <= bus_wdata;
                end
                if (bus_addr == ADR_SPUR) spur_q    <= bus_wdata;
                if (bus_addr == ADR_DBG)  protect_q <= bus_wdata[0];
            end
            if (rd_vec) begin
                mem_valid_q <= protect_q && active;
                mem_src_q   <= best_idx;
                mem_prio_q  <= best_prio;
            end else if (protect_take) begin
                mem_valid_q <= 1'b0;
            end
            if (push) status_q <= ack_src;
        end
    end

    // Read data mux; a vector read returns the winner's vector or the spurious one.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[4:3] == 2'b00 && int'(word_idx) < N_SRC)
            bus_rdata = DATA_W'(cfg_q[word_idx]);
        else if (bus_addr[4:3] == 2'b01 && int'(word_idx) < N_SRC)
            bus_rdata = vec_q[word_idx];
        else if (bus_addr == ADR_VECRD)
            bus_rdata = active ? vec_q[best_idx] : spur_q;
        else if (bus_addr == ADR_SPUR)
            bus_rdata = spur_q;
        else if (bus_addr == ADR_DBG)
            bus_rdata = DATA_W'(protect_q);
        else if (bus_addr == ADR_STATUS)
            bus_rdata = DATA_W'(status_q);
    end

    AST_PROTECT_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        protect_q && rd_vec && !bus_wr |=> $stable(status_q) && $stable(cur_lvl)); // R7
    AST_NORMAL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !protect_q && wr_vec && !bus_rd |=> $stable(status_q) && $stable(cur_lvl)); // R8
    AST_SPURIOUS_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec && irq_n && !bus_wr |=> $stable(cur_lvl) && $stable(status_q)); // R5
    AST_TAKE_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec && !protect_q && !irq_n |=> cur_lvl > $past(cur_lvl)); // R4
endmodule

// File: tb/irq_vector_ctrl_bench.sv
// Directed bench for the vectored interrupt controller.
module irq_vector_ctrl_bench;
    localparam int N_SRC  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src_in = '0;
    logic              irq_n;
    logic              bus_rd = 1'b0, bus_wr = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    irq_vector_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W), .STACK_DEPTH(8)) u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .irq_n(irq_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic pulse_src(input int s);
        @(negedge clk); src_in[s] = 1'b1;
        @(negedge clk); src_in[s] = 1'b0;
        #1;
    endtask

    task automatic read_status_chk(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(5'd20, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
        bus_read(5'd19, d);
        chk("R1 protect bit after reset", d, 32'd0);
        read_status_chk("R1 status after reset", 32'd0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(5'd0, 32'h1A);   // src0 prio 2 edge enabled
        bus_write(5'd1, 32'h15);   // src1 prio 5 level enabled
        bus_write(5'd2, 32'h1D);   // src2 prio 5 edge enabled
        bus_write(5'd3, 32'h0F);   // src3 prio 7 edge disabled
        for (int i = 0; i < N_SRC; i++) bus_write(5'(8 + i), 32'h100 + 32'(i) * 32'h10);
        bus_write(5'd17, 32'hDEAD);
        bus_read(5'd2, d);
        chk("R9 config readback", d, 32'h1D);
    endtask

    task automatic t_spurious();
        logic [31:0] d;
        chk("R2 no request idle", 32'(irq_n), 32'd1);
        bus_read(5'd16, d);
        chk("R5 spurious vector", d, 32'hDEAD);
        chk("R5 irq_n after spurious", 32'(irq_n), 32'd1);
        read_status_chk("R5 status after spurious", 32'd0);
    endtask

    task automatic t_disabled();
        @(negedge clk); src_in[3] = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        chk("R2 disabled source ignored", 32'(irq_n), 32'd1);
        src_in[3] = 1'b0;
    endtask

    task automatic t_nested();
        logic [31:0] d;
        pulse_src(0);
        chk("R2 edge source raises irq", 32'(irq_n), 32'd0);
        bus_read(5'd16, d);
        chk("R3 vector of src0", d, 32'h100);
        chk("R9 edge acked irq released", 32'(irq_n), 32'd1);
        read_status_chk("R4 status src0", 32'd0);
        pulse_src(2);
        chk("R10 higher prio nests", 32'(irq_n), 32'd0);
        bus_read(5'd16, d);
        chk("R10 nested vector src2", d, 32'h120);
        read_status_chk("R4 status src2", 32'd2);
        bus_write(5'd18, 32'd0);
        bus_write(5'd18, 32'd0);
        bus_write(5'd18, 32'd0);   // extra EOI on empty stack
        pulse_src(0);
        chk("R6 idle level after pops", 32'(irq_n), 32'd0);
        bus_read(5'd16, d);
        chk("R6 take after empty pop", d, 32'h100);
        bus_write(5'd18, 32'd0);
        chk("R6 back to idle no request", 32'(irq_n), 32'd1);
    endtask

    task automatic t_tie();
        logic [31:0] d;
        @(negedge clk); src_in[1] = 1'b1; src_in[2] = 1'b1;
        @(negedge clk); src_in[2] = 1'b0;
        #1;
        bus_read(5'd16, d);
        chk("R3 tie lowest index", d, 32'h110);
        chk("R4 level raised equal prio masked", 32'(irq_n), 32'd1);
        read_status_chk("R4 status src1", 32'd1);
        bus_write(5'd18, 32'd0);
        chk("R6 pop restores idle", 32'(irq_n), 32'd0);
        bus_read(5'd16, d);
        chk("R9 level source not cleared", d, 32'h110);
        bus_write(5'd18, 32'd0);
        @(negedge clk); src_in[1] = 1'b0;
        @(negedge clk); #1;
        bus_read(5'd16, d);
        chk("R9 edge source still latched", d, 32'h120);
        bus_write(5'd18, 32'd0);
        bus_read(5'd16, d);
        chk("R5 spurious after all acked", d, 32'hDEAD);
        read_status_chk("R5 status kept", 32'd2);
    endtask

    task automatic t_normal_write();
        logic [31:0] d;
        pulse_src(0);
        bus_write(5'd16, 32'h55);
        chk("R8 normal write keeps irq", 32'(irq_n), 32'd0);
        read_status_chk("R8 normal write keeps status", 32'd2);
        bus_read(5'd16, d);
        chk("R8 read after write still takes", d, 32'h100);
        bus_write(5'd18, 32'd0);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        bus_write(5'd19, 32'd1);
        bus_read(5'd19, d);
        chk("R7 protect bit set", d, 32'd1);
        pulse_src(2);
        for (int k = 0; k < 3; k++) begin
            bus_read(5'd16, d);
            chk("R7 repeated protect read", d, 32'h120);
            chk("R7 irq held across reads", 32'(irq_n), 32'd0);
        end
        read_status_chk("R7 status unchanged by reads", 32'd0);
        bus_write(5'd16, 32'hFFFF_FFFF);
        chk("R7 write commits ack", 32'(irq_n), 32'd1);
        read_status_chk("R7 status after commit", 32'd2);
        bus_write(5'd18, 32'd0);
        chk("R9 protect ack cleared edge", 32'(irq_n), 32'd1);
        bus_write(5'd19, 32'd0);
        bus_read(5'd19, d);
        chk("R7 protect bit cleared", d, 32'd0);
        pulse_src(0);
        bus_read(5'd16, d);
        chk("R4 normal again vector", d, 32'h100);
        read_status_chk("R4 normal again status", 32'd0);
        bus_write(5'd18, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_config();
        t_spurious();
        t_disabled();
        t_nested();
        t_tie();
        t_normal_write();
        t_protect();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule